// File: doc/BRIEF.md
# Four-Channel DMA Register Front End and Start Sequencer

This block holds the programming registers of four identical DMA channels behind one shared register bus. It decides when each channel may start a transfer, and it hands transfers one at a time to an external data mover through a request/done handshake. Each channel has an external-side address, a system-side address, a byte length, a mode field, a direction bit, an enable bit, a start bit and a stop field. Every register keeps only the bits defined for it.

A transfer needs two separate control bits: enable and start. A write to either bit makes the channel look at both. If both are one, the channel becomes pending. If enable is one and start is zero, any pending launch is dropped. If enable is zero, nothing changes, and the stored start bit waits for a later enable write. Pending channels are served in fixed priority, lowest number first. The mover receives a snapshot of the channel's addresses, length and direction. When the mover reports completion, the channel's start bit is cleared and that channel's completion event pulses.

Top module: `dmx_ctrl`

## Requirements
- R1: After reset every channel register reads zero, `mv_req` is low and `done_evt` is zero.
- R2: `reg_addr` is a word offset. Its top two bits select the channel, which is byte-offset bits 6:5. Its low three bits select the register: 0 external address, 1 system address, 2 length, 3 mode, 4 direction, 5 enable, 6 start, 7 stop. A write changes only the addressed register of the addressed channel, and `reg_rdata` returns the addressed register.
- R3: On write, the two addresses and the length keep the bits of 0x9FFFFFE0. Mode keeps bits 2:0. Direction, enable and start each keep bit 0. Stop keeps the bits of 0x37.
- R4: When an enable or start write leaves an idle system with enable=1 and start=1, `mv_req` rises one cycle after the write. The payload is `mv_chan`, both addresses, `mv_len` = length AND 0x1FFFFFFF, and `mv_dir`, where 0 means system-to-device and 1 means device-to-system.
- R5: A start write of 1 while enable is 0 launches nothing, and start reads back 1. A later enable write of 1 launches the transfer.
- R6: A start write of 0 while enable is 1 cancels a pending launch that has not yet been granted.
- R7: Channels that are pending together are served one at a time, lowest channel number first.
- R8: `mv_done` sampled while `mv_req` is high ends the transfer. In the next cycle `mv_req` is low, the channel's start bit reads 0, and `done_evt` has only the channel's bit set, for exactly one cycle.
- R9: While a channel is being served, writes to its registers are stored and read back, but the payload stays unchanged. Enable and start writes to that channel launch nothing.
- R10: `mv_done` while `mv_req` is low has no effect: no event is raised and no start bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word offset: channel in bits 4:3, register in bits 2:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mv_req | output | 1 | Transfer request to the mover, held until done |
| mv_done | input | 1 | Completion pulse from the mover |
| mv_chan | output | 2 | Channel being served |
| mv_ext | output | 32 | External-side address snapshot |
| mv_sys | output | 32 | System-side address snapshot |
| mv_len | output | 32 | Transfer length, bits 31:29 forced to zero |
| mv_dir | output | 1 | 0 system-to-device, 1 device-to-system |
| done_evt | output | 4 | One-cycle completion event per channel |

## Verification
A register write takes effect at the clock edge where the strobe is sampled, so read-back is due in the next cycle. A launch adds one edge: `mv_req` and its payload appear one cycle after the control write. The completion event and the fall of `mv_req` come one cycle after `mv_done` is sampled. The bench drives on falling edges and samples on falling edges. Its mover model pops each expected transfer when `mv_req` first shows, compares the payload on every busy cycle, and checks the event and request state on the cycle right after its done pulse.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int DATA_W = 32;
  localparam int MODE_W = 3;
  localparam int STOP_W = 6;
  localparam logic [DATA_W-1:0] ADDR_KEEP = 32'h9FFF_FFE0;
  localparam logic [DATA_W-1:0] LEN_XFER  = 32'h1FFF_FFFF;
  localparam logic [STOP_W-1:0] STOP_KEEP = 6'h37;

  typedef enum logic [2:0] {
    RI_EXT  = 3'd0,
    RI_SYS  = 3'd1,
    RI_LEN  = 3'd2,
    RI_MODE = 3'd3,
    RI_DIR  = 3'd4,
    RI_EN   = 3'd5,
    RI_GO   = 3'd6,
    RI_STOP = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [DATA_W-1:0] ext;
    logic [DATA_W-1:0] sys;
    logic [DATA_W-1:0] len;
    logic              dir;
  } xfer_t;
endpackage

// File: rtl/dmx_rst_sync.sv
module dmx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  reg_idx_e          wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  reg_idx_e          rd_idx,
  input  logic              busy_here,
  input  logic              grant,
  input  logic              done_clr,
  output logic              pend,
  output xfer_t             xfer,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ext_q, sys_q, len_q;
  logic [MODE_W-1:0] mode_q;
  logic [STOP_W-1:0] stop_q;
  logic              dir_q;
  logic              en_q, en_d;
  logic              go_q, go_d;
  logic              pend_q, pend_d;
  logic              ext_ld, sys_ld, len_ld, mode_ld, dir_ld, stop_ld;
  logic              ctl_wr;

  assign ext_ld  = wr_sel && (wr_idx == RI_EXT);
  assign sys_ld  = wr_sel && (wr_idx == RI_SYS);
  assign len_ld  = wr_sel && (wr_idx == RI_LEN);
  assign mode_ld = wr_sel && (wr_idx == RI_MODE);
  assign dir_ld  = wr_sel && (wr_idx == RI_DIR);
  assign stop_ld = wr_sel && (wr_idx == RI_STOP);
  assign ctl_wr  = wr_sel && ((wr_idx == RI_EN) || (wr_idx == RI_GO));

  // control next state: store the bit, then evaluate both bits together
  always_comb begin
    en_d   = en_q;
    go_d   = go_q;
    pend_d = pend_q;
    if (wr_sel && (wr_idx == RI_EN)) en_d = wdata[0];
    if (wr_sel && (wr_idx == RI_GO)) go_d = wdata[0];
    if (ctl_wr && !busy_here) begin
      if (en_d && go_d) begin
        pend_d = 1'b1;
      end else if (en_d) begin
        pend_d = 1'b0;
        go_d   = 1'b0;
      end
    end
    if (grant)    pend_d = 1'b0;
    if (done_clr) go_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      sys_q  <= '0;
      len_q  <= '0;
      mode_q <= '0;
      dir_q  <= 1'b0;
      stop_q <= '0;
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ext_ld)  ext_q  <= wdata & ADDR_KEEP;
      if (sys_ld)  sys_q  <= wdata & ADDR_KEEP;
      if (len_ld)  len_q  <= wdata & ADDR_KEEP;
      if (mode_ld) mode_q <= wdata[MODE_W-1:0];
      if (dir_ld)  dir_q  <= wdata[0];
      if (stop_ld) stop_q <= wdata[STOP_W-1:0] & STOP_KEEP;
      en_q   <= en_d;
      go_q   <= go_d;
      pend_q <= pend_d;
    end
  end

  assign pend     = pend_q;
  assign xfer.ext = ext_q;
  assign xfer.sys = sys_q;
  assign xfer.len = len_q & LEN_XFER;
  assign xfer.dir = dir_q;

  always_comb begin
    unique case (rd_idx)
      RI_EXT:  rdata = ext_q;
      RI_SYS:  rdata = sys_q;
      RI_LEN:  rdata = len_q;
      RI_MODE: rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
      RI_DIR:  rdata = {{(DATA_W-1){1'b0}}, dir_q};
      RI_EN:   rdata = {{(DATA_W-1){1'b0}}, en_q};
      RI_GO:   rdata = {{(DATA_W-1){1'b0}}, go_q};
      default: rdata = {{(DATA_W-STOP_W){1'b0}}, stop_q};
    endcase
  end
endmodule

// File: rtl/dmx_pick.sv
module dmx_pick #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend,
  output logic              any,
  output logic [CH_W-1:0]   idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/dmx_launch.sv
module dmx_launch
  import dmx_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    any,
  input  logic [CH_W-1:0]         idx,
  input  xfer_t [NUM_CH-1:0]      xfer_all,
  input  logic                    mv_done,
  output logic [NUM_CH-1:0]       grant,
  output logic [NUM_CH-1:0]       fin,
  output logic                    mv_req,
  output logic [CH_W-1:0]         mv_chan,
  output xfer_t                   mv_xfer,
  output logic [NUM_CH-1:0]       evt
);
  logic              busy_q, busy_d;
  logic [CH_W-1:0]   cur_q, cur_d;
  xfer_t             snap_q, snap_d;
  logic              snap_ld;
  logic [NUM_CH-1:0] evt_q;

  always_comb begin
    busy_d  = busy_q;
    cur_d   = cur_q;
    snap_d  = snap_q;
    snap_ld = 1'b0;
    grant   = '0;
    fin     = '0;
    if (!busy_q) begin
      if (any) begin
        busy_d     = 1'b1;
        cur_d      = idx;
        snap_d     = xfer_all[idx];
        snap_ld    = 1'b1;
        grant[idx] = 1'b1;
      end
    end else if (mv_done) begin
      busy_d     = 1'b0;
      fin[cur_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      snap_q <= '0;
      evt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      if (snap_ld) snap_q <= snap_d;
      evt_q  <= fin;
    end
  end

  assign mv_req  = busy_q;
  assign mv_chan = cur_q;
  assign mv_xfer = snap_q;
  assign evt     = evt_q;
endmodule

// File: rtl/dmx_ctrl.sv
module dmx_ctrl
  import dmx_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int WA_W = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mv_req,
  input  logic              mv_done,
  output logic [CH_W-1:0]   mv_chan,
  output logic [DATA_W-1:0] mv_ext,
  output logic [DATA_W-1:0] mv_sys,
  output logic [DATA_W-1:0] mv_len,
  output logic              mv_dir,
  output logic [NUM_CH-1:0] done_evt
);
  logic                          rst_sync_n;
  logic [CH_W-1:0]               ch_sel;
  reg_idx_e                      r_idx;
  logic [NUM_CH-1:0]             pend, grant, fin;
  logic                          any;
  logic [CH_W-1:0]               pick_idx;
  xfer_t [NUM_CH-1:0]            xfer_all;
  xfer_t                         mv_xfer;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;

  assign ch_sel = reg_addr[WA_W-1:3];
  assign r_idx  = reg_idx_e'(reg_addr[2:0]);

  dmx_rst_sync rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmx_chan ch_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_sel   (reg_wr && (ch_sel == CH_W'(g))),
      .wr_idx   (r_idx),
      .wdata    (reg_wdata),
      .rd_idx   (r_idx),
      .busy_here(mv_req && (mv_chan == CH_W'(g))),
      .grant    (grant[g]),
      .done_clr (fin[g]),
      .pend     (pend[g]),
      .xfer     (xfer_all[g]),
      .rdata    (ch_rdata[g])
    );
  end

  dmx_pick #(.NUM_CH(NUM_CH)) pick_i (
    .pend(pend),
    .any (any),
    .idx (pick_idx)
  );

  dmx_launch #(.NUM_CH(NUM_CH)) launch_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .any     (any),
    .idx     (pick_idx),
    .xfer_all(xfer_all),
    .mv_done (mv_done),
    .grant   (grant),
    .fin     (fin),
    .mv_req  (mv_req),
    .mv_chan (mv_chan),
    .mv_xfer (mv_xfer),
    .evt     (done_evt)
  );

  assign mv_ext = mv_xfer.ext;
  assign mv_sys = mv_xfer.sys;
  assign mv_len = mv_xfer.len;
  assign mv_dir = mv_xfer.dir;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_W'(i)) reg_rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/dmx_ctrl_chk.sv
module dmx_ctrl_chk #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mv_req,
  input logic              mv_done,
  input logic [CH_W-1:0]   mv_chan,
  input logic [31:0]       mv_ext,
  input logic [31:0]       mv_sys,
  input logic [31:0]       mv_len,
  input logic              mv_dir,
  input logic [NUM_CH-1:0] done_evt
);
  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mv_req) |-> $past(mv_done));

  // R8
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_evt));

  // R10
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |-> ($past(mv_req && mv_done)
                          && done_evt == (NUM_CH'(1) << $past(mv_chan))));

  // R9
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && $past(mv_req)) |-> ($stable(mv_chan) && $stable(mv_ext)
      && $stable(mv_sys) && $stable(mv_len) && $stable(mv_dir)));

  // R4
  len_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> (mv_len[31:29] == 3'b000));
endmodule

bind dmx_ctrl dmx_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .mv_req  (mv_req),
  .mv_done (mv_done),
  .mv_chan (mv_chan),
  .mv_ext  (mv_ext),
  .mv_sys  (mv_sys),
  .mv_len  (mv_len),
  .mv_dir  (mv_dir),
  .done_evt(done_evt)
);

// File: tb/dmx_ctrl_tb_top.sv
module dmx_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int MOVER_DLY  = 20;
  localparam logic [31:0] AKEEP = 32'h9FFF_FFE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mv_req, mv_dir;
  logic        mover_done = 1'b0, force_done = 1'b0;
  logic        mv_done;
  logic [1:0]  mv_chan;
  logic [31:0] mv_ext, mv_sys, mv_len;
  logic [3:0]  done_evt;

  assign mv_done = mover_done | force_done;
  always #(CLK_PERIOD/2) clk = ~clk;

  dmx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mv_req(mv_req),
    .mv_done(mv_done), .mv_chan(mv_chan), .mv_ext(mv_ext), .mv_sys(mv_sys),
    .mv_len(mv_len), .mv_dir(mv_dir), .done_evt(done_evt)
  );

  typedef struct {
    int          ch;
    logic [31:0] ext, sys, len;
    logic        dir;
  } item_t;

  item_t       exp_q[$];
  int          n_chk = 0, n_fail = 0, done_seen = 0;
  bit          finished = 0;
  logic [31:0] m_ext[NCH], m_sys[NCH], m_len[NCH];
  logic        m_dir[NCH];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input int ch, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = {ch[1:0], idx[2:0]};
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output logic [31:0] v);
    @(negedge clk);
    reg_wr   = 1'b0;
    reg_addr = {ch[1:0], idx[2:0]};
    #1 v = reg_rdata;
  endtask

  task automatic rd_chk(input int ch, input int idx, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(ch, idx, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic cfg(input int ch, input logic [31:0] e, input logic [31:0] s,
                     input logic [31:0] l, input logic d);
    wr(ch, 0, e); m_ext[ch] = e & AKEEP;
    wr(ch, 1, s); m_sys[ch] = s & AKEEP;
    wr(ch, 2, l); m_len[ch] = l & AKEEP;
    wr(ch, 4, {31'd0, d}); m_dir[ch] = d;
  endtask

  task automatic push_exp(input int ch);
    item_t it;
    it.ch  = ch;
    it.ext = m_ext[ch];
    it.sys = m_sys[ch];
    it.len = m_len[ch] & 32'h1FFF_FFFF;
    it.dir = m_dir[ch];
    exp_q.push_back(it);
  endtask

  task automatic wait_done(input int target);
    while (done_seen < target) @(negedge clk);
  endtask

  // scoreboard monitor and mover model
  initial begin
    item_t cur;
    int    cnt;
    bit    active;
    active = 0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (active) begin
        if (mover_done) begin
          mover_done = 1'b0;
          active = 0;
          chk(done_evt == (4'b1 << cur.ch), "R8 done_evt", {28'd0, done_evt}, 32'(4'b1 << cur.ch));
          chk(!mv_req, "R8 mv_req low after done", {31'd0, mv_req}, 32'd0);
          done_seen++;
        end else begin
          chk(mv_req && mv_ext == cur.ext && mv_sys == cur.sys && mv_len == cur.len
              && mv_dir == cur.dir && mv_chan == cur.ch[1:0],
              "R9 payload held", mv_ext, cur.ext);
          cnt++;
          if (cnt == MOVER_DLY) mover_done = 1'b1;
        end
      end else begin
        if (done_evt != '0) chk(0, "R10 unexpected done_evt", {28'd0, done_evt}, 32'd0);
        if (mv_req) begin
          if (exp_q.size() == 0) begin
            chk(0, "R4 unexpected launch", {30'd0, mv_chan}, 32'hFFFF_FFFF);
            cur.ch = int'(mv_chan); cur.ext = mv_ext; cur.sys = mv_sys;
            cur.len = mv_len; cur.dir = mv_dir;
          end else begin
            cur = exp_q.pop_front();
            chk(mv_chan == cur.ch[1:0], "R7 served channel", {30'd0, mv_chan}, cur.ch);
            chk(mv_ext == cur.ext && mv_sys == cur.sys, "R4 addresses", mv_ext, cur.ext);
            chk(mv_len == cur.len, "R4 length", mv_len, cur.len);
            chk(mv_dir == cur.dir, "R4 direction", {31'd0, mv_dir}, {31'd0, cur.dir});
          end
          active = 1;
          cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_ext[i] = '0; m_sys[i] = '0; m_len[i] = '0; m_dir[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!mv_req, "R1 mv_req", {31'd0, mv_req}, 32'd0);
    chk(done_evt == '0, "R1 done_evt", {28'd0, done_evt}, 32'd0);
    rd_chk(0, 0, 32'd0, "R1 ch0 ext");
    rd_chk(3, 7, 32'd0, "R1 ch3 stop");
    rd_chk(2, 6, 32'd0, "R1 ch2 start");

    // R3 write masks on channel 1
    cfg(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    wr(1, 3, 32'hFFFF_FFFF);
    wr(1, 7, 32'hFFFF_FFFF);
    wr(1, 5, 32'hFFFF_FFFE);
    rd_chk(1, 0, 32'h9FFF_FFE0, "R3 ext mask");
    rd_chk(1, 1, 32'h9FFF_FFE0, "R3 sys mask");
    rd_chk(1, 2, 32'h9FFF_FFE0, "R3 len mask");
    rd_chk(1, 3, 32'h0000_0007, "R3 mode mask");
    rd_chk(1, 4, 32'h0000_0001, "R3 dir mask");
    rd_chk(1, 7, 32'h0000_0037, "R3 stop mask");
    rd_chk(1, 5, 32'h0000_0000, "R3 enable keeps bit 0");

    // R2 decode: channel 2 write leaves channels 1 and 3 alone
    wr(2, 0, 32'h1234_5660); m_ext[2] = 32'h1234_5660 & AKEEP;
    rd_chk(2, 0, 32'h1234_5660 & AKEEP, "R2 ch2 ext");
    rd_chk(1, 0, 32'h9FFF_FFE0, "R2 ch1 ext untouched");
    rd_chk(3, 0, 32'h0000_0000, "R2 ch3 ext untouched");

    // R4 launch on channel 0
    cfg(0, 32'h8000_0020, 32'h0C00_0040, 32'hFFFF_FFFF, 1'b1);
    wr(0, 5, 32'd1);
    repeat (3) @(negedge clk);
    chk(!mv_req, "R4 enable alone launches nothing", {31'd0, mv_req}, 32'd0);
    push_exp(0);
    wr(0, 6, 32'd1);
    chk(!mv_req, "R4 request not before edge", {31'd0, mv_req}, 32'd0);
    @(negedge clk);
    chk(mv_req, "R4 request one cycle after write", {31'd0, mv_req}, 32'd1);
    wait_done(1);
    rd_chk(0, 6, 32'd0, "R8 start cleared");

    // R5 start while disabled, R10 stray done
    wr(1, 6, 32'd1);
    repeat (5) @(negedge clk);
    chk(!mv_req, "R5 no launch while disabled", {31'd0, mv_req}, 32'd0);
    rd_chk(1, 6, 32'd1, "R5 start kept");
    @(negedge clk); force_done = 1'b1;
    @(negedge clk); force_done = 1'b0;
    @(negedge clk);
    chk(done_evt == '0, "R10 no event", {28'd0, done_evt}, 32'd0);
    rd_chk(1, 6, 32'd1, "R10 start unchanged");
    push_exp(1);
    wr(1, 5, 32'd1);
    wait_done(2);
    rd_chk(1, 6, 32'd0, "R8 ch1 start cleared");

    // R7 priority, R6 cancel, R9 busy writes
    cfg(2, 32'h0000_1000, 32'h0000_2000, 32'h0000_0040, 1'b0);
    cfg(3, 32'h0000_3000, 32'h0000_4000, 32'h0000_0080, 1'b1);
    wr(2, 5, 32'd1);
    wr(3, 5, 32'd1);
    push_exp(0);
    wr(0, 6, 32'd1);
    repeat (3) @(negedge clk);
    wr(3, 6, 32'd1);
    wr(2, 6, 32'd1);
    wr(1, 6, 32'd1);
    wr(1, 6, 32'd0);
    wr(0, 0, 32'h0000_0FE0);
    wr(0, 6, 32'd1);
    push_exp(2);
    push_exp(3);
    wait_done(5);
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected transfers served", exp_q.size(), 0);
    chk(!mv_req, "R6 cancelled channel not served", {31'd0, mv_req}, 32'd0);
    rd_chk(0, 0, 32'h0000_0FE0, "R9 busy write stored");
    rd_chk(0, 6, 32'd0, "R9 busy start write no relaunch");
    rd_chk(1, 6, 32'd0, "R6 start reads zero");

    summary();
    $finish;
  end
endmodule